// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation buffer. Each entry maps a pair of neighbouring virtual pages, an even one and an odd one, onto two independent physical frames. Every entry carries its own page-size mask, so small and large pages can sit in the table side by side. An entry also holds an address-space tag and a global flag, plus a frame number, a valid bit and a dirty bit for each half of the pair. A plain write port loads one entry per cycle.

A lookup presents a virtual address, the current address-space tag, a read/write flag and a quiet flag. One cycle later the block returns one of two results. A success carries the physical address and whether the page may be written. A fault is sorted into one of three kinds: a miss needing refill, a hit on an invalid page, or a write to a clean page. The fault is returned with the faulting address, its VPN2 field and the address-space tag. A quiet lookup that fails reports only that it failed. The translation control logic of a processor pipeline uses the block to turn load and store addresses into physical ones and to raise its memory-management faults.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset, rsp_valid, rsp_ok and rsp_exc are 0. Every entry has all fields zero: mask 0, VPN2 0, tag 0, not global, frames 0, both halves invalid and clean.
- R2: A lookup sampled with lk_req high on a rising edge gives rsp_valid high after that edge. A cycle without lk_req gives rsp_valid low. A write to an entry is seen by lookups sampled on the next edge or later.
- R3: A mask of zero gives a page shift of 12. A nonzero mask gives shift s when (mask | 0x1FFF) equals 2^(s+1)-1, for even s from 12 to 26.
- R4: An entry's VPN2 (address bits 31..13) is compared with the address only from bit s+1 upward. A success returns PA = (selected frame << 12) | (address & (2^s - 1)).
- R5: An entry matches only when its tag equals lk_asid or its global bit is set.
- R6: Address bit s chooses the odd half (bit set) or the even half (bit clear). That half supplies the frame, the valid bit and the dirty bit.
- R7: A matching valid page reports success (rsp_ok=1) with rsp_rw equal to its dirty bit, except for a write to a clean page. rsp_ok and rsp_exc are never high together.
- R8: A write to a matching valid clean page faults with rsp_code 0 (modified) and rsp_refill 0.
- R9: A match on an invalid half faults with rsp_code 1 for a read or 2 for a write, and rsp_refill 0.
- R10: With no matching entry, the lookup faults with rsp_code 1 for a read or 2 for a write, and rsp_refill 1. Every fault returns rsp_bad_va = lk_va, rsp_bad_vpn2 = lk_va[31:13] and rsp_bad_asid = lk_asid.
- R11: When lk_quiet is set, a failing lookup returns rsp_ok=0 and rsp_exc=0, and no fault is signalled. A succeeding quiet lookup returns its normal success.
- R12: An entry whose nonzero mask fits none of the patterns of R3 never matches.
- R13: When several entries match, the lowest-indexed one supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | IDX_W | Entry index to load |
| wr_mask | input | MASK_W | Page-size mask |
| wr_vpn2 | input | VA_W-13 | Virtual page-pair number (address bits 31..13) |
| wr_asid | input | ASID_W | Address-space tag |
| wr_global | input | 1 | Match under any tag |
| wr_pfn_even | input | PFN_W | Frame of the even page |
| wr_valid_even | input | 1 | Even page valid |
| wr_dirty_even | input | 1 | Even page writable |
| wr_pfn_odd | input | PFN_W | Frame of the odd page |
| wr_valid_odd | input | 1 | Odd page valid |
| wr_dirty_odd | input | 1 | Odd page writable |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_write | input | 1 | Access is a store |
| lk_quiet | input | 1 | Suppress fault reporting |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_rw | output | 1 | Page is writable (success only) |
| rsp_pa | output | PFN_W+12 | Physical address |
| rsp_exc | output | 1 | Fault signalled |
| rsp_code | output | 2 | 0 modified, 1 load fault, 2 store fault |
| rsp_refill | output | 1 | Fault was a miss |
| rsp_bad_va | output | VA_W | Faulting address |
| rsp_bad_vpn2 | output | VA_W-13 | VPN2 of the faulting address |
| rsp_bad_asid | output | ASID_W | Tag of the faulting lookup |

## Verification
Each legal page size from 4 KB up to 64 MB is loaded in turn and probed at both page halves, at the first and last bytes of the pair, just past the pair, and under a foreign tag. This separates the comparison boundary from the odd-half selector and from the offset pass-through. Reads and writes against dirty and clean halves tell success, read-only and modified faults apart. Invalid halves, misses, global entries, overlapping entries and illegal masks separate the three fault kinds from one another and from priority effects. A pseudo-random sweep over a table of mixed page sizes, with quiet and loud lookups, covers the remaining combinations.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;

   typedef enum logic [1:0] {
      EXC_MOD  = 2'd0,
      EXC_LOAD = 2'd1,
      EXC_STOR = 2'd2
   } tlb_exc_e;

   typedef struct packed {
      logic       legal;
      logic [4:0] shift;
   } page_dec_t;

   localparam int unsigned MIN_SHIFT = 12;
   localparam int unsigned MAX_SHIFT = 26;
   localparam logic [31:0] LOW_FILL  = 32'h0000_1FFF;

   // Turns a raw page-size mask into a page shift; odd masks are flagged illegal.
   function automatic page_dec_t decode_page(input logic [31:0] m);
      page_dec_t r;
      r.legal = 1'b0;
      r.shift = 5'(MIN_SHIFT);
      if (m == 32'd0) begin
         r.legal = 1'b1;
      end else begin
         for (int k = MIN_SHIFT; k <= MAX_SHIFT; k += 2) begin
            if ((m | LOW_FILL) == ((32'd1 << (k + 1)) - 32'd1)) begin
               r.legal = 1'b1;
               r.shift = 5'(k);
            end
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
   parameter int NUM_ENTRIES = 8,
   parameter int VA_W        = 32,
   parameter int ASID_W      = 8,
   parameter int PFN_W       = 20,
   parameter int MASK_W      = 27,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [IDX_W-1:0]                    wr_idx,
   input  logic [MASK_W-1:0]                   wr_mask,
   input  logic [VA_W-14:0]                    wr_vpn2,
   input  logic [ASID_W-1:0]                   wr_asid,
   input  logic                                wr_global,
   input  logic [PFN_W-1:0]                    wr_pfn_even,
   input  logic                                wr_valid_even,
   input  logic                                wr_dirty_even,
   input  logic [PFN_W-1:0]                    wr_pfn_odd,
   input  logic                                wr_valid_odd,
   input  logic                                wr_dirty_odd,
   output logic [NUM_ENTRIES-1:0][MASK_W-1:0]  ent_mask,
   output logic [NUM_ENTRIES-1:0][VA_W-14:0]   ent_vpn2,
   output logic [NUM_ENTRIES-1:0][ASID_W-1:0]  ent_asid,
   output logic [NUM_ENTRIES-1:0]              ent_global,
   output logic [NUM_ENTRIES-1:0][PFN_W-1:0]   ent_pfn_even,
   output logic [NUM_ENTRIES-1:0]              ent_valid_even,
   output logic [NUM_ENTRIES-1:0]              ent_dirty_even,
   output logic [NUM_ENTRIES-1:0][PFN_W-1:0]   ent_pfn_odd,
   output logic [NUM_ENTRIES-1:0]              ent_valid_odd,
   output logic [NUM_ENTRIES-1:0]              ent_dirty_odd
);

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_mask[e]       <= '0;
            ent_vpn2[e]       <= '0;
            ent_asid[e]       <= '0;
            ent_global[e]     <= 1'b0;
            ent_pfn_even[e]   <= '0;
            ent_valid_even[e] <= 1'b0;
            ent_dirty_even[e] <= 1'b0;
            ent_pfn_odd[e]    <= '0;
            ent_valid_odd[e]  <= 1'b0;
            ent_dirty_odd[e]  <= 1'b0;
         end else if (sel) begin
            ent_mask[e]       <= wr_mask;
            ent_vpn2[e]       <= wr_vpn2;
            ent_asid[e]       <= wr_asid;
            ent_global[e]     <= wr_global;
            ent_pfn_even[e]   <= wr_pfn_even;
            ent_valid_even[e] <= wr_valid_even;
            ent_dirty_even[e] <= wr_dirty_even;
            ent_pfn_odd[e]    <= wr_pfn_odd;
            ent_valid_odd[e]  <= wr_valid_odd;
            ent_dirty_odd[e]  <= wr_dirty_odd;
         end
      end
   end

endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
   import tlb_pair_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int ASID_W = 8,
   parameter int PFN_W  = 20,
   parameter int MASK_W = 27
) (
   input  logic [MASK_W-1:0] mask,
   input  logic [VA_W-14:0]  vpn2,
   input  logic [ASID_W-1:0] asid,
   input  logic              global_map,
   input  logic [PFN_W-1:0]  pfn_even,
   input  logic              valid_even,
   input  logic              dirty_even,
   input  logic [PFN_W-1:0]  pfn_odd,
   input  logic              valid_odd,
   input  logic              dirty_odd,
   input  logic [VA_W-1:0]   va,
   input  logic [ASID_W-1:0] cur_asid,
   output logic              hit,
   output logic [PFN_W-1:0]  sel_pfn,
   output logic              sel_valid,
   output logic              sel_dirty,
   output logic [VA_W-1:0]   off_mask
);

   localparam logic [VA_W-1:0] ONE = VA_W'(1);

   page_dec_t       dec;
   logic [VA_W-1:0] tag_addr;
   logic [VA_W-1:0] keep;
   logic [5:0]      cmp_lsb;
   logic            odd;
   logic            tag_ok;

   assign dec      = decode_page(32'(mask));
   assign cmp_lsb  = {1'b0, dec.shift} + 6'd1;
   assign tag_addr = {vpn2, 13'b0};
   assign keep     = ~((ONE << cmp_lsb) - ONE);
   assign off_mask = (ONE << dec.shift) - ONE;
   assign odd      = |((va >> dec.shift) & ONE);
   assign tag_ok   = (asid == cur_asid) || global_map;
   assign hit      = dec.legal && (((tag_addr ^ va) & keep) == '0) && tag_ok;

   assign sel_pfn   = odd ? pfn_odd   : pfn_even;
   assign sel_valid = odd ? valid_odd : valid_even;
   assign sel_dirty = odd ? dirty_odd : dirty_even;

endmodule

// File: rtl/tlb_hit_pick.sv
module tlb_hit_pick #(
   parameter int NUM_ENTRIES = 8,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic [NUM_ENTRIES-1:0] hits,
   output logic                   any,
   output logic [IDX_W-1:0]       idx
);

   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
   import tlb_pair_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int VA_W        = 32,
   parameter int ASID_W      = 8,
   parameter int PFN_W       = 20,
   parameter int MASK_W      = 27,
   localparam int IDX_W      = $clog2(NUM_ENTRIES),
   localparam int PA_W       = PFN_W + 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [VA_W-14:0]  wr_vpn2,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PFN_W-1:0]  wr_pfn_even,
   input  logic              wr_valid_even,
   input  logic              wr_dirty_even,
   input  logic [PFN_W-1:0]  wr_pfn_odd,
   input  logic              wr_valid_odd,
   input  logic              wr_dirty_odd,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   input  logic              lk_quiet,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic              rsp_rw,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_exc,
   output logic [1:0]        rsp_code,
   output logic              rsp_refill,
   output logic [VA_W-1:0]   rsp_bad_va,
   output logic [VA_W-14:0]  rsp_bad_vpn2,
   output logic [ASID_W-1:0] rsp_bad_asid
);

   // Elaboration-time parameter checks
   if (NUM_ENTRIES < 2) begin : g_chk_entries
      $error("tlb_pair_lookup: NUM_ENTRIES must be at least 2");
   end
   if (VA_W < 28 || VA_W > 64) begin : g_chk_va
      $error("tlb_pair_lookup: VA_W must cover bit 27 and stay within 64");
   end
   if (MASK_W < 13 || MASK_W > 32) begin : g_chk_mask
      $error("tlb_pair_lookup: MASK_W must lie in 13..32");
   end
   if (PA_W < 27) begin : g_chk_pa
      $error("tlb_pair_lookup: PFN_W too small to hold the largest page offset");
   end

   logic [NUM_ENTRIES-1:0][MASK_W-1:0] ent_mask;
   logic [NUM_ENTRIES-1:0][VA_W-14:0]  ent_vpn2;
   logic [NUM_ENTRIES-1:0][ASID_W-1:0] ent_asid;
   logic [NUM_ENTRIES-1:0]             ent_global;
   logic [NUM_ENTRIES-1:0][PFN_W-1:0]  ent_pfn_even;
   logic [NUM_ENTRIES-1:0]             ent_valid_even;
   logic [NUM_ENTRIES-1:0]             ent_dirty_even;
   logic [NUM_ENTRIES-1:0][PFN_W-1:0]  ent_pfn_odd;
   logic [NUM_ENTRIES-1:0]             ent_valid_odd;
   logic [NUM_ENTRIES-1:0]             ent_dirty_odd;

   tlb_entry_store #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .VA_W        (VA_W),
      .ASID_W      (ASID_W),
      .PFN_W       (PFN_W),
      .MASK_W      (MASK_W)
   ) u_store (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .wr_idx         (wr_idx),
      .wr_mask        (wr_mask),
      .wr_vpn2        (wr_vpn2),
      .wr_asid        (wr_asid),
      .wr_global      (wr_global),
      .wr_pfn_even    (wr_pfn_even),
      .wr_valid_even  (wr_valid_even),
      .wr_dirty_even  (wr_dirty_even),
      .wr_pfn_odd     (wr_pfn_odd),
      .wr_valid_odd   (wr_valid_odd),
      .wr_dirty_odd   (wr_dirty_odd),
      .ent_mask       (ent_mask),
      .ent_vpn2       (ent_vpn2),
      .ent_asid       (ent_asid),
      .ent_global     (ent_global),
      .ent_pfn_even   (ent_pfn_even),
      .ent_valid_even (ent_valid_even),
      .ent_dirty_even (ent_dirty_even),
      .ent_pfn_odd    (ent_pfn_odd),
      .ent_valid_odd  (ent_valid_odd),
      .ent_dirty_odd  (ent_dirty_odd)
   );

   logic [NUM_ENTRIES-1:0]            cell_hit;
   logic [NUM_ENTRIES-1:0][PFN_W-1:0] cell_pfn;
   logic [NUM_ENTRIES-1:0]            cell_valid;
   logic [NUM_ENTRIES-1:0]            cell_dirty;
   logic [NUM_ENTRIES-1:0][VA_W-1:0]  cell_off;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cell
      tlb_match_cell #(
         .VA_W   (VA_W),
         .ASID_W (ASID_W),
         .PFN_W  (PFN_W),
         .MASK_W (MASK_W)
      ) u_cell (
         .mask       (ent_mask[e]),
         .vpn2       (ent_vpn2[e]),
         .asid       (ent_asid[e]),
         .global_map (ent_global[e]),
         .pfn_even   (ent_pfn_even[e]),
         .valid_even (ent_valid_even[e]),
         .dirty_even (ent_dirty_even[e]),
         .pfn_odd    (ent_pfn_odd[e]),
         .valid_odd  (ent_valid_odd[e]),
         .dirty_odd  (ent_dirty_odd[e]),
         .va         (lk_va),
         .cur_asid   (lk_asid),
         .hit        (cell_hit[e]),
         .sel_pfn    (cell_pfn[e]),
         .sel_valid  (cell_valid[e]),
         .sel_dirty  (cell_dirty[e]),
         .off_mask   (cell_off[e])
      );
   end

   logic             any_hit;
   logic [IDX_W-1:0] win_idx;

   tlb_hit_pick #(
      .NUM_ENTRIES (NUM_ENTRIES)
   ) u_pick (
      .hits (cell_hit),
      .any  (any_hit),
      .idx  (win_idx)
   );

   logic [PFN_W-1:0] win_pfn;
   logic             win_valid;
   logic             win_dirty;
   logic [VA_W-1:0]  win_off;

   assign win_pfn   = cell_pfn[win_idx];
   assign win_valid = cell_valid[win_idx];
   assign win_dirty = cell_dirty[win_idx];
   assign win_off   = cell_off[win_idx];

   logic      nx_ok;
   logic      nx_rw;
   logic      nx_fail;
   logic      nx_exc;
   logic      nx_refill;
   tlb_exc_e  nx_code;
   logic [PA_W-1:0] nx_pa;
   tlb_exc_e  access_fault;

   assign access_fault = lk_write ? EXC_STOR : EXC_LOAD;

   always_comb begin
      nx_ok     = 1'b0;
      nx_rw     = 1'b0;
      nx_fail   = 1'b0;
      nx_refill = 1'b0;
      nx_code   = access_fault;
      if (any_hit) begin
         if (win_valid) begin
            if (win_dirty) begin
               nx_ok = 1'b1;
               nx_rw = 1'b1;
            end else if (!lk_write) begin
               nx_ok = 1'b1;
            end else begin
               nx_fail = 1'b1;
               nx_code = EXC_MOD;
            end
         end else begin
            nx_fail = 1'b1;
         end
      end else begin
         nx_fail   = 1'b1;
         nx_refill = 1'b1;
      end
      nx_exc = nx_fail && !lk_quiet;
      nx_pa  = nx_ok ? ((PA_W'(win_pfn) << 12) | PA_W'(lk_va & win_off)) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_ok       <= 1'b0;
         rsp_rw       <= 1'b0;
         rsp_pa       <= '0;
         rsp_exc      <= 1'b0;
         rsp_code     <= '0;
         rsp_refill   <= 1'b0;
         rsp_bad_va   <= '0;
         rsp_bad_vpn2 <= '0;
         rsp_bad_asid <= '0;
      end else begin
         rsp_valid    <= lk_req;
         rsp_ok       <= lk_req && nx_ok;
         rsp_rw       <= lk_req && nx_rw;
         rsp_pa       <= lk_req ? nx_pa : '0;
         rsp_exc      <= lk_req && nx_exc;
         rsp_code     <= (lk_req && nx_exc) ? nx_code : EXC_MOD;
         rsp_refill   <= lk_req && nx_exc && nx_refill;
         rsp_bad_va   <= (lk_req && nx_exc) ? lk_va : '0;
         rsp_bad_vpn2 <= (lk_req && nx_exc) ? lk_va[VA_W-1:13] : '0;
         rsp_bad_asid <= (lk_req && nx_exc) ? lk_asid : '0;
      end
   end

endmodule

// File: rtl/tlb_pair_checker.sv
module tlb_pair_checker
   import tlb_pair_pkg::*;
#(
   parameter int VA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_req,
   input logic [VA_W-1:0] lk_va,
   input logic            lk_write,
   input logic            lk_quiet,
   input logic            rsp_valid,
   input logic            rsp_ok,
   input logic            rsp_rw,
   input logic            rsp_exc,
   input logic [1:0]      rsp_code,
   input logic            rsp_refill,
   input logic [VA_W-1:0] rsp_bad_va
);

   assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rsp_valid);

   assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rsp_valid);

   assert_ok_exc_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_ok && rsp_exc));

   assert_rw_needs_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rw |-> rsp_ok);

   assert_mod_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && !lk_write) |=> !(rsp_exc && rsp_code == EXC_MOD));

   assert_mod_not_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_exc && rsp_code == EXC_MOD) |-> !rsp_refill);

   assert_quiet_no_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && lk_quiet) |=> !rsp_exc);

   assert_fault_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && !lk_quiet) |=> (!rsp_exc || rsp_bad_va == $past(lk_va)));

endmodule

bind tlb_pair_lookup tlb_pair_checker #(.VA_W(VA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_req     (lk_req),
   .lk_va      (lk_va),
   .lk_write   (lk_write),
   .lk_quiet   (lk_quiet),
   .rsp_valid  (rsp_valid),
   .rsp_ok     (rsp_ok),
   .rsp_rw     (rsp_rw),
   .rsp_exc    (rsp_exc),
   .rsp_code   (rsp_code),
   .rsp_refill (rsp_refill),
   .rsp_bad_va (rsp_bad_va)
);

// File: tb/test_tlb_pair_lookup.sv
`timescale 1ns/1ps
module test_tlb_pair_lookup;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [26:0] wr_mask = '0;
   logic [18:0] wr_vpn2 = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [19:0] wr_pfn_even = '0;
   logic        wr_valid_even = 1'b0;
   logic        wr_dirty_even = 1'b0;
   logic [19:0] wr_pfn_odd = '0;
   logic        wr_valid_odd = 1'b0;
   logic        wr_dirty_odd = 1'b0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_write = 1'b0;
   logic        lk_quiet = 1'b0;
   logic        rsp_valid, rsp_ok, rsp_rw, rsp_exc, rsp_refill;
   logic [31:0] rsp_pa;
   logic [1:0]  rsp_code;
   logic [31:0] rsp_bad_va;
   logic [18:0] rsp_bad_vpn2;
   logic [7:0]  rsp_bad_asid;

   always #4 clk = ~clk;

   tlb_pair_lookup i_tlb_pair_lookup (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_idx (wr_idx), .wr_mask (wr_mask), .wr_vpn2 (wr_vpn2),
      .wr_asid (wr_asid), .wr_global (wr_global),
      .wr_pfn_even (wr_pfn_even), .wr_valid_even (wr_valid_even), .wr_dirty_even (wr_dirty_even),
      .wr_pfn_odd (wr_pfn_odd), .wr_valid_odd (wr_valid_odd), .wr_dirty_odd (wr_dirty_odd),
      .lk_req (lk_req), .lk_va (lk_va), .lk_asid (lk_asid), .lk_write (lk_write), .lk_quiet (lk_quiet),
      .rsp_valid (rsp_valid), .rsp_ok (rsp_ok), .rsp_rw (rsp_rw), .rsp_pa (rsp_pa),
      .rsp_exc (rsp_exc), .rsp_code (rsp_code), .rsp_refill (rsp_refill),
      .rsp_bad_va (rsp_bad_va), .rsp_bad_vpn2 (rsp_bad_vpn2), .rsp_bad_asid (rsp_bad_asid)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] seed = 32'h1234_5678;

   // Shadow of the table, kept from the writes the bench issues
   logic [26:0] t_mask [N];
   logic [18:0] t_vpn  [N];
   logic [7:0]  t_asid [N];
   logic        t_g    [N];
   logic [19:0] t_pfn0 [N];
   logic        t_v0   [N];
   logic        t_d0   [N];
   logic [19:0] t_pfn1 [N];
   logic        t_v1   [N];
   logic        t_d1   [N];

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   function automatic logic [26:0] mask_for(input int k);
      if (k == 12) return 27'h0;
      return 27'(((32'd1 << (k + 1)) - 32'd1) & ~32'h1FFF);
   endfunction

   task automatic check(input bit ok, input string tag, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", tag, what);
      end
   endtask

   task automatic load(input int idx, input logic [26:0] m, input logic [18:0] vpn,
                       input logic [7:0] as, input bit g,
                       input logic [19:0] p0, input bit v0, input bit d0,
                       input logic [19:0] p1, input bit v1, input bit d1);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'(idx); wr_mask = m; wr_vpn2 = vpn; wr_asid = as; wr_global = g;
      wr_pfn_even = p0; wr_valid_even = v0; wr_dirty_even = d0;
      wr_pfn_odd = p1; wr_valid_odd = v1; wr_dirty_odd = d1;
      t_mask[idx] = m; t_vpn[idx] = vpn; t_asid[idx] = as; t_g[idx] = g;
      t_pfn0[idx] = p0; t_v0[idx] = v0; t_d0[idx] = d0;
      t_pfn1[idx] = p1; t_v1[idx] = v1; t_d1[idx] = d1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(input logic [31:0] va, input logic [7:0] as, input bit wr,
                         input bit q, input string tag);
      bit e_ok, e_rw, e_exc, e_refill, fail, found, legal;
      logic [1:0] e_code;
      logic [31:0] e_pa;
      int s, w;
      bit bad;
      e_ok = 0; e_rw = 0; e_exc = 0; e_refill = 0; fail = 0; found = 0;
      e_code = wr ? 2'd2 : 2'd1; e_pa = '0; w = 0; s = 12;
      for (int i = 0; i < N && !found; i++) begin
         int si;
         legal = 0; si = 12;
         if (t_mask[i] == 0) legal = 1;
         else for (int k = 12; k <= 26; k += 2)
            if ((32'(t_mask[i]) | 32'h1FFF) == ((32'd1 << (k + 1)) - 1)) begin legal = 1; si = k; end
         if (legal && ((va >> (si + 1)) == ({t_vpn[i], 13'b0} >> (si + 1)))
             && (t_asid[i] == as || t_g[i])) begin
            found = 1; w = i; s = si;
         end
      end
      if (found) begin
         bit odd, v, d;
         logic [19:0] p;
         odd = va[s];
         v = odd ? t_v1[w] : t_v0[w];
         d = odd ? t_d1[w] : t_d0[w];
         p = odd ? t_pfn1[w] : t_pfn0[w];
         if (v && (d || !wr)) begin
            e_ok = 1; e_rw = d;
            e_pa = ({p, 12'b0}) | (va & ((32'd1 << s) - 1));
         end else begin
            fail = 1;
            if (v) e_code = 2'd0;
         end
      end else begin
         fail = 1; e_refill = 1;
      end
      if (fail && !q) e_exc = 1; else e_refill = 0;

      @(negedge clk);
      lk_req = 1'b1; lk_va = va; lk_asid = as; lk_write = wr; lk_quiet = q;
      @(negedge clk);
      bad = (rsp_valid !== 1'b1) || (rsp_ok !== e_ok) || (rsp_rw !== e_rw) || (rsp_exc !== e_exc)
            || (e_ok && rsp_pa !== e_pa)
            || (e_exc && (rsp_code !== e_code || rsp_refill !== e_refill || rsp_bad_va !== va
                          || rsp_bad_vpn2 !== va[31:13] || rsp_bad_asid !== as));
      check(!bad, tag, $sformatf(
         "va=%h as=%h wr=%0d q=%0d got ok=%0d rw=%0d pa=%h exc=%0d code=%0d ref=%0d badva=%h exp ok=%0d rw=%0d pa=%h exc=%0d code=%0d ref=%0d",
         va, as, wr, q, rsp_ok, rsp_rw, rsp_pa, rsp_exc, rsp_code, rsp_refill, rsp_bad_va,
         e_ok, e_rw, e_pa, e_exc, e_code, e_refill));
      lk_req = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         t_mask[i] = '0; t_vpn[i] = '0; t_asid[i] = '0; t_g[i] = 0;
         t_pfn0[i] = '0; t_v0[i] = 0; t_d0[i] = 0; t_pfn1[i] = '0; t_v1[i] = 0; t_d1[i] = 0;
      end
      repeat (3) @(negedge clk);
      check(rsp_valid === 0 && rsp_ok === 0 && rsp_exc === 0, "R1",
            $sformatf("in reset got valid=%0d ok=%0d exc=%0d exp 0 0 0", rsp_valid, rsp_ok, rsp_exc));
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid === 0 && rsp_ok === 0 && rsp_exc === 0, "R1",
            $sformatf("after reset got valid=%0d ok=%0d exc=%0d exp 0 0 0", rsp_valid, rsp_ok, rsp_exc));

      // R1 / R9: zeroed entries match page pair 0 under tag 0 but are invalid
      lookup(32'h0000_0010, 8'h00, 0, 0, "R1 zero table invalid load R9");
      lookup(32'h0000_1010, 8'h00, 1, 0, "R1 zero table invalid store R9");
      @(negedge clk);
      check(rsp_valid === 0, "R2", $sformatf("valid after idle got %0d exp 0", rsp_valid));

      // R3 R4 R6 R7 R8: sweep every legal page size on entry 1
      for (int k = 12; k <= 26; k += 2) begin
         logic [18:0] vpn;
         logic [31:0] base, span;
         logic [26:0] m;
         vpn  = 19'(rnd() >> 13) | 19'h40000;
         span = 32'd1 << (k + 1);
         base = {vpn, 13'b0} & ~(span - 1);
         m    = mask_for(k);
         if (k == 12) m = 27'h0;
         load(1, m, vpn, 8'h33, 0, 20'(rnd()), 1, 1, 20'(rnd()), 1, 0);
         lookup(base, 8'h33, 0, 0, "R3 R4 even first byte");
         lookup(base + (span >> 1) - 1, 8'h33, 1, 0, "R4 R7 even last byte rw");
         lookup(base + (span >> 1), 8'h33, 0, 0, "R6 R7 odd first byte read-only");
         lookup(base + span - 1, 8'h33, 1, 0, "R6 R8 odd write to clean");
         lookup(base + span, 8'h33, 0, 0, "R4 R10 just past pair");
         lookup(base + (32'(rnd()) & (span - 1)), 8'h34, 0, 0, "R5 R10 foreign tag");
         lookup(base + (32'(rnd()) & (span - 1)), 8'h33, 1, 0, "R4 R6 inner store");
      end
      // Non-zero mask with only low bits still means 4 KB
      load(1, 27'h0000FFF, 19'h2ABCD, 8'h33, 0, 20'h11111, 1, 1, 20'h22222, 1, 1);
      lookup({19'h2ABCD, 13'h1234}, 8'h33, 0, 0, "R3 low-only mask");

      // R12: illegal masks never match
      load(1, 27'h0003000, 19'h2ABCD, 8'h33, 0, 20'h11111, 1, 1, 20'h22222, 1, 1);
      lookup({19'h2ABCD, 13'h0004}, 8'h33, 0, 0, "R12 mask 0x3000 miss");
      load(1, 27'h0016000, 19'h2ABCC, 8'h33, 1, 20'h11111, 1, 1, 20'h22222, 1, 1);
      lookup({19'h2ABCC, 13'h0004}, 8'h77, 1, 0, "R12 mask 0x16000 miss");

      // R5: global entry matches under any tag
      load(2, 27'h0, 19'h31000, 8'h10, 1, 20'hABCDE, 1, 1, 20'hBCDEF, 1, 1);
      lookup({19'h31000, 13'h0123}, 8'h99, 0, 0, "R5 global other tag");
      lookup({19'h31000, 13'h1FFF}, 8'h10, 1, 0, "R5 global own tag");

      // R9: invalid half faults without refill
      load(3, 27'h0, 19'h32000, 8'h10, 0, 20'h00001, 0, 1, 20'h00002, 1, 1);
      lookup({19'h32000, 13'h0040}, 8'h10, 1, 0, "R9 invalid even store");
      lookup({19'h32000, 13'h0040}, 8'h10, 0, 0, "R9 invalid even load");
      lookup({19'h32000, 13'h1040}, 8'h10, 0, 0, "R6 valid odd beside invalid even");

      // R13: overlapping entries, lowest index wins
      load(4, 27'h0, 19'h33000, 8'h10, 0, 20'h44444, 1, 1, 20'h44445, 1, 1);
      load(5, 27'h0, 19'h33000, 8'h10, 0, 20'h55555, 1, 0, 20'h55556, 0, 0);
      lookup({19'h33000, 13'h0ABC}, 8'h10, 1, 0, "R13 twin entries");
      load(6, mask_for(16), 19'h34000, 8'h10, 0, 20'h66660, 1, 1, 20'h66670, 1, 1);
      load(7, 27'h0, 19'h34001, 8'h10, 0, 20'h77777, 0, 0, 20'h77778, 0, 0);
      lookup({19'h34001, 13'h0055}, 8'h10, 0, 0, "R13 large page before small");

      // R11: quiet lookups
      lookup(32'hDEAD_0000, 8'h10, 0, 1, "R11 quiet miss");
      lookup({19'h32000, 13'h0040}, 8'h10, 1, 1, "R11 quiet invalid");
      lookup({19'h33000, 13'h1000}, 8'h33, 1, 1, "R11 quiet foreign tag");
      load(5, 27'h0, 19'h35000, 8'h10, 0, 20'h55555, 1, 0, 20'h55556, 1, 0);
      lookup({19'h35000, 13'h0010}, 8'h10, 1, 1, "R11 quiet modified");
      lookup({19'h35000, 13'h0010}, 8'h10, 0, 1, "R11 quiet success");

      // R2: back-to-back write then lookup sees the new entry
      load(0, 27'h0, 19'h36000, 8'h22, 0, 20'h0C0C0, 1, 1, 20'h0D0D0, 1, 1);
      lookup({19'h36000, 13'h1FFC}, 8'h22, 0, 0, "R2 new entry visible");

      // Mixed table, pseudo-random sweep
      for (int e = 0; e < N; e++) begin
         int k;
         logic [26:0] m;
         k = 12 + 2 * int'(rnd() % 8);
         m = (e == 7) ? 27'h0005000 : mask_for(k);
         load(e, m, 19'(rnd() >> 13), 8'(e % 3), (rnd() % 5) == 0,
              20'(rnd()), (rnd() % 4) != 0, rnd() % 2 == 0,
              20'(rnd()), (rnd() % 4) != 0, rnd() % 2 == 0);
      end
      for (int n = 0; n < 600; n++) begin
         int e;
         e = int'(rnd() % N);
         lookup({t_vpn[e], 13'b0} ^ (rnd() & 32'h0003_FFFF), 8'(rnd() % 3),
                rnd() % 2 == 0, rnd() % 6 == 0, "R4 R7 R10 R13 sweep");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got hang exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule